// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This controller picks the clock that drives the core and the peripherals from one of two raw sources: a slow internal oscillator and a primary oscillator. A 2-bit select input names the wanted source. The value 2'b11 asks for internal-oscillator run. Each of the other three values asks for primary run. The controller's own state machine runs on the internal clock. On a request for the primary source, the machine switches the primary oscillator on and keeps the system clock on the internal oscillator. A start-up timer counts primary periods to qualify the primary clock. When the PLL is enabled, a lock delay measured in internal cycles follows the timer. After both, the output moves to the primary clock with no runt pulse and a ready flag is raised.

The handover gates the old clock off while it is low, in its own domain. It gates the new clock on only after a two-flop synchronisation in the new clock's domain. The two gates are never open together. If the select input changes before a pending switch completes, the controller drops that switch and acts on the newest value. A later request runs the full start-up timer again. The internal oscillator enable drops in primary run only when neither the watchdog flag nor the fail-safe monitor flag is set. A request to return to the internal source raises that enable again at once, without waiting for a clock.

Top module: `clk_sw_ctrl`

## Requirements
- R1: With sel_i = 2'b11 held, the system clock follows clk_int_i, pri_osc_en_o is 0 and osc_ready_o is 0.
- R2: With sel_i at 2'b00, 2'b01 or 2'b10, pri_osc_en_o is 1. While the qualification is still running, the system clock stays on clk_int_i and osc_ready_o stays 0.
- R3: osc_ready_o rises no earlier than OST_CYC primary clock periods after pri_osc_en_o went high.
- R4: With pll_en_i = 1, osc_ready_o also waits at least LOCK_CYC internal periods after the start-up timer. Measured from pri_osc_en_o going high, that is at least LOCK_CYC plus the internal periods spanned by OST_CYC primary periods.
- R5: While osc_ready_o is 1, clk_sys_o follows clk_pri_i.
- R6: clk_sys_o never shows a high or low phase shorter than the shorter half period of the two sources, and the two source gates are never open together.
- R7: int_osc_en_o is 1 whenever osc_ready_o is 0. In primary run it equals wdt_en_i OR fscm_en_i.
- R8: Setting sel_i back to 2'b11 before osc_ready_o rises cancels the switch: osc_ready_o stays 0 and pri_osc_en_o falls. A new primary request then runs the full OST_CYC start-up again.
- R9: During and just after reset, osc_ready_o is 0, pri_osc_en_o is 1 (start-up toward the primary source) and clk_sys_o follows clk_int_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int_i | input | 1 | Internal oscillator clock; clocks the controller |
| clk_pri_i | input | 1 | Primary oscillator clock, PLL output when the PLL is used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Source select; 2'b11 internal, others primary |
| pll_en_i | input | 1 | Adds the PLL lock delay to the qualification |
| wdt_en_i | input | 1 | Watchdog enabled; keeps the internal oscillator on |
| fscm_en_i | input | 1 | Fail-safe monitor enabled; keeps the internal oscillator on |
| clk_sys_o | output | 1 | Switched system clock |
| osc_ready_o | output | 1 | Set when the system clock runs from the primary source |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| int_osc_en_o | output | 1 | Internal oscillator enable |

## Verification
The bench times every phase of clk_sys_o across all handovers. A mux that switched on the raw select, or opened a gate before the other one closed, would produce a short phase there. The ready flag is timed against primary and internal edge counts taken since the primary enable rose, with and without the PLL. A timer that started early or skipped the lock delay would raise the flag too soon. One case abandons a request partway through and then restarts it. A timer that kept its partial count would then finish early. The oscillator keep-alive flags are toggled in primary run, and random select sequences are compared against expected source, flag and enable values.

// File: rtl/clk_sw_pkg.sv
`timescale 1ns/1ps
package clk_sw_pkg;
  typedef enum logic [2:0] {
    ST_INT,     // running from internal osc
    ST_OST,     // primary start-up timer running
    ST_PLL,     // PLL lock wait
    ST_SWITCH,  // handover in flight
    ST_PRI      // running from primary
  } sw_state_e;
endpackage

// File: rtl/clk_sw_sync.sv
`timescale 1ns/1ps
module clk_sw_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/clk_sw_ost.sv
`timescale 1ns/1ps
// Start-up timer in the primary domain; restarts whenever enable is seen low.
module clk_sw_ost #(
  parameter int OST_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o,
  output logic en_o
);
  localparam int CW = (OST_CYC > 1) ? $clog2(OST_CYC) : 1;

  logic [CW-1:0] cnt_q;

  clk_sw_sync #(.RST_VAL(1'b0)) u_en_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!en_o) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == CW'(OST_CYC - 1)) done_o <= 1'b1;
      else                           cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_sw_gate.sv
`timescale 1ns/1ps
// Glitch-free two-source mux: each gate changes on its own falling edge,
// after a two-flop sync of the request qualified by the other gate being shut.
module clk_sw_gate (
  input  logic clk_int_i,
  input  logic clk_pri_i,
  input  logic rst_ni,
  input  logic want_pri_i,
  output logic int_on_o,
  output logic pri_on_o,
  output logic clk_o
);
  logic int_req_s, pri_req_s;

  clk_sw_sync #(.RST_VAL(1'b1)) u_int_sync (
    .clk_i (clk_int_i),
    .rst_ni(rst_ni),
    .d_i   (~want_pri_i & ~pri_on_o),
    .q_o   (int_req_s)
  );

  clk_sw_sync #(.RST_VAL(1'b0)) u_pri_sync (
    .clk_i (clk_pri_i),
    .rst_ni(rst_ni),
    .d_i   (want_pri_i & ~int_on_o),
    .q_o   (pri_req_s)
  );

  always_ff @(negedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) int_on_o <= 1'b1;
    else         int_on_o <= int_req_s;
  end

  always_ff @(negedge clk_pri_i or negedge rst_ni) begin
    if (!rst_ni) pri_on_o <= 1'b0;
    else         pri_on_o <= pri_req_s;
  end

  assign clk_o = (clk_int_i & int_on_o) | (clk_pri_i & pri_on_o);
endmodule

// File: rtl/clk_sw_ctrl.sv
`timescale 1ns/1ps
module clk_sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int OST_CYC  = 1024,
  parameter int LOCK_CYC = 16000
) (
  input  logic       clk_int_i,
  input  logic       clk_pri_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       pll_en_i,
  input  logic       wdt_en_i,
  input  logic       fscm_en_i,
  output logic       clk_sys_o,
  output logic       osc_ready_o,
  output logic       pri_osc_en_o,
  output logic       int_osc_en_o
);
  localparam int LW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC + 1) : 1;

  sw_state_e state_q, state_n;
  logic [LW-1:0] lock_cnt_q;
  logic want_pri_q;
  logic sel_int_raw, sel_int_s, pll_s;
  logic ost_done, ost_en_echo, ost_done_s, ost_echo_s;
  logic int_on, pri_on, pri_on_s;

  assign sel_int_raw = &sel_i;

  clk_sw_sync #(.RST_VAL(1'b0)) u_sel_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(sel_int_raw), .q_o(sel_int_s));
  clk_sw_sync #(.RST_VAL(1'b0)) u_pll_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(pll_en_i), .q_o(pll_s));
  clk_sw_sync #(.RST_VAL(1'b0)) u_done_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(ost_done), .q_o(ost_done_s));
  clk_sw_sync #(.RST_VAL(1'b0)) u_echo_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(ost_en_echo), .q_o(ost_echo_s));
  clk_sw_sync #(.RST_VAL(1'b0)) u_pon_sync (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(pri_on), .q_o(pri_on_s));

  clk_sw_ost #(.OST_CYC(OST_CYC)) u_ost (
    .clk_i (clk_pri_i),
    .rst_ni(rst_ni),
    .en_i  (pri_osc_en_o),
    .done_o(ost_done),
    .en_o  (ost_en_echo)
  );

  clk_sw_gate u_gate (
    .clk_int_i (clk_int_i),
    .clk_pri_i (clk_pri_i),
    .rst_ni    (rst_ni),
    .want_pri_i(want_pri_q),
    .int_on_o  (int_on),
    .pri_on_o  (pri_on),
    .clk_o     (clk_sys_o)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      // leave only once the timer has visibly reset and the primary gate is shut
      ST_INT:    if (!sel_int_s && !ost_done_s && !ost_echo_s && !pri_on_s) state_n = ST_OST;
      ST_OST:    if (sel_int_s) state_n = ST_INT;
                 else if (ost_done_s) state_n = pll_s ? ST_PLL : ST_SWITCH;
      ST_PLL:    if (sel_int_s) state_n = ST_INT;
                 else if (lock_cnt_q == LW'(LOCK_CYC - 1)) state_n = ST_SWITCH;
      ST_SWITCH: if (sel_int_s) state_n = ST_INT;
                 else if (pri_on_s) state_n = ST_PRI;
      ST_PRI:    if (sel_int_s) state_n = ST_INT;
      default:   state_n = ST_INT;
    endcase
  end

  always_ff @(posedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_OST;
      lock_cnt_q   <= '0;
      want_pri_q   <= 1'b0;
      osc_ready_o  <= 1'b0;
      pri_osc_en_o <= 1'b1;
    end else begin
      state_q      <= state_n;
      lock_cnt_q   <= (state_q == ST_PLL) ? lock_cnt_q + 1'b1 : '0;
      want_pri_q   <= (state_n == ST_SWITCH) || (state_n == ST_PRI);
      osc_ready_o  <= (state_n == ST_PRI);
      pri_osc_en_o <= (state_n != ST_INT) || pri_on_s;
    end
  end

  // raw select term wakes the internal osc without needing its clock
  assign int_osc_en_o = ~osc_ready_o | wdt_en_i | fscm_en_i | sel_int_raw;
endmodule

// File: rtl/clk_sw_ctrl_chk.sv
`timescale 1ns/1ps
module clk_sw_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_ready_i,
  input logic pri_osc_en_i,
  input logic int_osc_en_i,
  input logic pri_on_i,
  input logic int_on_i,
  input logic ost_done_i
);
  assert_ready_on_pri_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_ready_i |-> (pri_on_i && !int_on_i));

  assert_gates_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_on_i && int_on_i));

  assert_ready_after_timer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_ready_i) |-> ost_done_i);

  assert_ready_needs_pri_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_ready_i |-> pri_osc_en_i);

  assert_int_alive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_ready_i |-> int_osc_en_i);
endmodule

bind clk_sw_ctrl clk_sw_ctrl_chk u_chk (
  .clk_i       (clk_int_i),
  .rst_ni      (rst_ni),
  .osc_ready_i (osc_ready_o),
  .pri_osc_en_i(pri_osc_en_o),
  .int_osc_en_i(int_osc_en_o),
  .pri_on_i    (pri_on),
  .int_on_i    (int_on),
  .ost_done_i  (ost_done_s)
);

// File: tb/clk_sw_ctrl_tb.sv
`timescale 1ns/1ps
module clk_sw_ctrl_tb;
  localparam int OST  = 1024;
  localparam int LOCK = 300;
  localparam real TINT = 8.0;   // 125 MHz
  localparam real TPRI = 5.0;
  localparam int OST_IN_INT = (OST * 5) / 8;

  logic clk_int = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic pll = 1'b0, wdt = 1'b0, fscm = 1'b0;
  logic clk_sys, rdy, pri_en, int_en;

  int n_chk = 0, n_fail = 0;
  int pcnt = 0, icnt = 0, cap_p = 0, cap_i = 0;
  int glitches = 0;
  real last_t = 0.0;

  always #(TINT/2) clk_int = ~clk_int;
  always #(TPRI/2) clk_pri = ~clk_pri;

  clk_sw_ctrl #(.OST_CYC(OST), .LOCK_CYC(LOCK)) u_dut (
    .clk_int_i(clk_int), .clk_pri_i(clk_pri), .rst_ni(rst_n),
    .sel_i(sel), .pll_en_i(pll), .wdt_en_i(wdt), .fscm_en_i(fscm),
    .clk_sys_o(clk_sys), .osc_ready_o(rdy), .pri_osc_en_o(pri_en),
    .int_osc_en_o(int_en));

  always @(posedge clk_pri) begin
    if (!rst_n || !pri_en) pcnt = 0;
    else if (!rdy) pcnt = pcnt + 1;
  end
  always @(posedge clk_int) begin
    if (!rst_n || !pri_en) icnt = 0;
    else if (!rdy) icnt = icnt + 1;
  end
  always @(posedge rdy) begin
    cap_p = pcnt;
    cap_i = icnt;
  end
  always @(clk_sys) begin
    if (rst_n) begin
      if (last_t > 0.0 && ($realtime - last_t) < 2.4) glitches = glitches + 1;
      last_t = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic follow(input bit from_pri, input string req);
    for (int k = 0; k < 4; k++) begin
      if (from_pri) @(posedge clk_pri); else @(posedge clk_int);
      #1 chk(clk_sys == 1'b1, req, int'(clk_sys), 1);
      if (from_pri) @(negedge clk_pri); else @(negedge clk_int);
      #1 chk(clk_sys == 1'b0, req, int'(clk_sys), 0);
    end
  endtask

  task automatic wait_int(input int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (!rdy && k < 4000) begin
      @(posedge clk_int);
      k++;
    end
    #1 chk(rdy == 1'b1, req, int'(rdy), 1);
  endtask

  function automatic bit exp_ready(input logic [1:0] s);
    return s != 2'b11;
  endfunction
  function automatic bit exp_int_en(input logic [1:0] s, input bit w, input bit f);
    return (s == 2'b11) ? 1'b1 : (w | f);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_int);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R9: reset state
    #20;
    chk(rdy == 1'b0, "R9 ready", int'(rdy), 0);
    chk(pri_en == 1'b1, "R9 pri_en", int'(pri_en), 1);
    chk(int_en == 1'b1, "R9 int_en", int'(int_en), 1);
    @(negedge clk_int) rst_n = 1'b1;
    wait_int(2);
    chk(rdy == 1'b0, "R9 ready after release", int'(rdy), 0);
    follow(1'b0, "R9 clock on internal");

    // R3: start-up from reset, no PLL
    wait_ready("R3 ready");
    chk(cap_p >= OST, "R3 primary periods", cap_p, OST);
    follow(1'b1, "R5 follows primary");
    chk(int_en == 1'b0, "R7 int off", int'(int_en), 0);
    wdt = 1'b1; #1;
    chk(int_en == 1'b1, "R7 wdt keeps int", int'(int_en), 1);
    wdt = 1'b0; fscm = 1'b1; #1;
    chk(int_en == 1'b1, "R7 fscm keeps int", int'(int_en), 1);
    fscm = 1'b0; #1;
    chk(int_en == 1'b0, "R7 int off again", int'(int_en), 0);

    // R1: to internal
    sel = 2'b11;
    wait_int(40);
    chk(rdy == 1'b0, "R1 ready", int'(rdy), 0);
    chk(pri_en == 1'b0, "R1 pri_en", int'(pri_en), 0);
    follow(1'b0, "R1 clock on internal");

    // R4: with PLL lock wait
    pll = 1'b1; sel = 2'b01;
    wait_ready("R4 ready");
    chk(cap_p >= OST, "R4 primary periods", cap_p, OST);
    chk(cap_i >= LOCK + OST_IN_INT, "R4 internal periods", cap_i, LOCK + OST_IN_INT);

    // R8: abandon and restart
    sel = 2'b11;
    wait_int(40);
    pll = 1'b0; sel = 2'b10;
    wait_int(200);
    chk(pri_en == 1'b1, "R2 pri_en during start-up", int'(pri_en), 1);
    chk(rdy == 1'b0, "R2 not ready yet", int'(rdy), 0);
    follow(1'b0, "R2 clock held on internal");
    sel = 2'b11;
    wait_int(40);
    chk(rdy == 1'b0, "R8 cancelled ready", int'(rdy), 0);
    chk(pri_en == 1'b0, "R8 cancelled pri_en", int'(pri_en), 0);
    sel = 2'b00;
    wait_ready("R8 restart ready");
    chk(cap_p >= OST, "R8 full timer rerun", cap_p, OST);

    // random select sequences
    for (int it = 0; it < 16; it++) begin
      logic [1:0] s;
      s = 2'($urandom());
      pll = 1'($urandom());
      wdt = 1'($urandom());
      fscm = 1'($urandom());
      sel = s;
      wait_int(1300);
      chk(rdy == exp_ready(s), "R1/R2 random ready", int'(rdy), int'(exp_ready(s)));
      chk(pri_en == exp_ready(s), "R2 random pri_en", int'(pri_en), int'(exp_ready(s)));
      chk(int_en == exp_int_en(s, wdt, fscm), "R7 random int_en", int'(int_en),
          int'(exp_int_en(s, wdt, fscm)));
      follow(exp_ready(s), "R5 random source");
    end

    chk(glitches == 0, "R6 short phases", glitches, 0);
    finish_run();
  end
endmodule